// File: doc/BRIEF.md
# Table-Driven Start-Up Writer for an External USB Device Controller

This block sets up an external USB device-controller chip after a reset, with no processor involved. It keeps the chip in reset for a short time and then releases it. It waits a settling interval. It then reads a small on-chip table of 16-bit words one by one, starting at address 0, and writes each word to the chip over an asynchronous parallel bus.

Every write is framed by active-low select and write strobes. A single address line tells the chip whether the word on the bus is a command code (line high) or a register value (line low). The table holds the register settings in command/value pairs. The sequence ends when a terminator word appears in a command slot, or after the word at the last table address. At that point a done flag rises and stays high until the next reset.

The table content is computed at elaboration. It writes these registers, in order: the operating-mode register, the hardware-setup register, the interrupt-mask register, and sixteen endpoint-setup registers.

Top module: `usbdc_init_seq`

## Requirements
- R1: While `rst` is high, `usb_rst_n_o` is 0, `usb_cs_n_o`, `usb_wr_n_o` and `usb_rd_n_o` are 1, `usb_a1_o` is 1, and `init_done_o` is 0.
- R2: After `rst` falls, `usb_rst_n_o` stays low for `RST_HOLD_CYCLES` cycles and then goes high. No chip select occurs while it is low. No write strobe begins before `SETTLE_CYCLES` cycles have passed with it high.
- R3: Words are written in table order from address 0. Table index i holds the following. i0 = 0x00B8 and i1 = 0x0008 (mode; bit 3 is the global interrupt enable). i2 = 0x00BA and i3 = 0x0040 (hardware setup; bit 0 = 0 makes the interrupt output active low). i4 = 0x00C2 and i5 = 0x0107 (interrupt mask). For k = 0..15, i(6+2k) = 0x0020+k and i(7+2k) is the endpoint-setup value: k0 = 0x0083, k1 = 0x008B, k2 = 0x00CB, k3 = 0x0080, k4 = 0x0088, and all other k = 0x0000. Every index from 38 upward holds 0xFFFF.
- R4: `usb_a0_o` is 1 during writes at even table positions (commands) and 0 during writes at odd positions (values).
- R5: For each word, `usb_wr_n_o` is low for exactly `WR_CYCLES` cycles. `usb_cs_n_o` is low for one cycle before the write strobe falls, throughout the strobe, and for one cycle after it rises.
- R6: `usb_data_o` and `usb_a0_o` are stable from the cycle before the write strobe falls through the cycle in which it rises.
- R7: `usb_rd_n_o` stays 1 and `usb_a1_o` stays 1 (device mode) at all times.
- R8: A word equal to 0xFFFF at a command position is not written. It ends the sequence, and `init_done_o` rises. With the default table, exactly 38 words are written.
- R9: If no terminator is met, the sequence ends after the word at address `ROM_DEPTH-1` has been written. With `ROM_DEPTH` = 16, exactly 16 words are written.
- R10: `init_done_o` stays high and no further strobes occur until `rst`. A reset in mid-sequence aborts the sequence, and the whole sequence restarts from address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| usb_data_o | output | 16 | Word driven to the chip data bus |
| usb_a0_o | output | 1 | Word kind: 1 command, 0 value |
| usb_a1_o | output | 1 | Mode select, held at 1 (device mode) |
| usb_cs_n_o | output | 1 | Chip select, active low |
| usb_wr_n_o | output | 1 | Write strobe, active low |
| usb_rd_n_o | output | 1 | Read strobe, active low, held inactive |
| usb_rst_n_o | output | 1 | Chip reset, active low |
| init_done_o | output | 1 | Sequence complete |

## Verification
The table is read through a registered port. Each word therefore reaches the bus two cycles after its address is set, and the chip select falls at the end of the decode cycle. The write strobe falls one cycle later and stays low for `WR_CYCLES` cycles. The chip select rises one cycle after the strobe rises.

After the terminator is decoded, the done flag goes high at the next edge. After a last-address stop, it goes high at the edge that ends the final hold cycle.

A bus watcher samples every output at the falling clock edge, half a cycle away from the edges where the outputs change. It captures each word at the edge where the strobe falls, and it measures strobe width, setup, hold and reset timing cycle by cycle. The directed tasks read the watcher only after a rising edge, and they wait for the done flag with a bounded count before comparing.

// File: rtl/usbdc_init_pkg.sv
package usbdc_init_pkg;

    typedef enum logic [2:0] {
        SQ_RSTHOLD,
        SQ_SETTLE,
        SQ_FETCH,
        SQ_DECODE,
        SQ_ISSUE,
        SQ_DONE
    } seq_state_e;

    typedef enum logic [1:0] {
        BE_IDLE,
        BE_SETUP,
        BE_STROBE,
        BE_HOLD
    } bus_state_e;

    typedef struct packed {
        logic [15:0] word;
        logic        is_cmd;
    } bus_word_t;

    localparam logic [15:0] END_MARK       = 16'hFFFF;
    localparam logic [15:0] CMD_MODE       = 16'h00B8;
    localparam logic [15:0] CMD_HWSETUP    = 16'h00BA;
    localparam logic [15:0] CMD_IRQMASK    = 16'h00C2;
    localparam logic [15:0] CMD_EPSET_BASE = 16'h0020;
    localparam logic [15:0] VAL_MODE       = 16'h0008;  // bit 3: global interrupt enable
    localparam logic [15:0] VAL_HWSETUP    = 16'h0040;  // bit 0 = 0: interrupt output active low
    localparam logic [15:0] VAL_IRQMASK    = 16'h0107;
    localparam int          NUM_EP_REGS    = 16;
    localparam int          HEAD_WORDS     = 6;
    localparam int          TABLE_WORDS    = HEAD_WORDS + 2 * NUM_EP_REGS;

    // Endpoint setup: bit7 enable, bit6 double buffer, bit3 direction in, bits1:0 size code
    function automatic logic [15:0] ep_setting(input int k);
        case (k)
            0:       return 16'h0083;  // control out, 64 bytes
            1:       return 16'h008B;  // control in, 64 bytes
            2:       return 16'h00CB;  // bulk in, 64 bytes, double buffered
            3:       return 16'h0080;  // interrupt out, 16 bytes
            4:       return 16'h0088;  // interrupt in, 16 bytes
            default: return 16'h0000;  // disabled
        endcase
    endfunction

    function automatic logic [15:0] cfg_word(input int idx);
        int k;
        if (idx >= TABLE_WORDS) return END_MARK;
        case (idx)
            0: return CMD_MODE;
            1: return VAL_MODE;
            2: return CMD_HWSETUP;
            3: return VAL_HWSETUP;
            4: return CMD_IRQMASK;
            5: return VAL_IRQMASK;
            default: begin
                k = (idx - HEAD_WORDS) / 2;
                if (idx % 2 == 0) return CMD_EPSET_BASE + 16'(k);
                return ep_setting(k);
            end
        endcase
    endfunction

endpackage

// File: rtl/usbdc_init_rom.sv
module usbdc_init_rom
    import usbdc_init_pkg::*;
#(
    parameter int ROM_DEPTH = 64,
    localparam int AW = $clog2(ROM_DEPTH)
) (
    input  logic          clk,
    input  logic [AW-1:0] addr,
    output logic [15:0]   rdata
);

    logic [15:0] mem [ROM_DEPTH];

    for (genvar g = 0; g < ROM_DEPTH; g++) begin : g_word
        assign mem[g] = cfg_word(g);
    end

    always_ff @(posedge clk) begin
        rdata <= mem[addr];
    end

endmodule

// File: rtl/usbdc_bus_writer.sv
module usbdc_bus_writer
    import usbdc_init_pkg::*;
#(
    parameter int WR_CYCLES = 4,
    localparam int CW = $clog2(WR_CYCLES + 1)
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  bus_word_t   word_in,
    output logic [15:0] bus_data_o,
    output logic        a0_o,
    output logic        cs_n_o,
    output logic        wr_n_o,
    output logic        word_done_o
);

    bus_state_e     st;
    logic [CW-1:0]  cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= BE_IDLE;
            cs_n_o     <= 1'b1;
            wr_n_o     <= 1'b1;
            bus_data_o <= '0;
            a0_o       <= 1'b0;
            cnt        <= '0;
        end else begin
            case (st)
                BE_IDLE: begin
                    if (start) begin
                        bus_data_o <= word_in.word;
                        a0_o       <= word_in.is_cmd;
                        cs_n_o     <= 1'b0;
                        st         <= BE_SETUP;
                    end
                end
                BE_SETUP: begin
                    wr_n_o <= 1'b0;
                    cnt    <= CW'(WR_CYCLES - 1);
                    st     <= BE_STROBE;
                end
                BE_STROBE: begin
                    if (cnt == '0) begin
                        wr_n_o <= 1'b1;
                        st     <= BE_HOLD;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                BE_HOLD: begin
                    cs_n_o <= 1'b1;
                    st     <= BE_IDLE;
                end
                default: st <= BE_IDLE;
            endcase
        end
    end

    assign word_done_o = (st == BE_HOLD);

    // R5: strobe only inside an active select
    assert_wr_in_cs_R5: assert property (@(posedge clk) disable iff (rst)
        !wr_n_o |-> !cs_n_o);

    // R5: select was already low the cycle before the strobe fell
    assert_cs_lead_R5: assert property (@(posedge clk) disable iff (rst)
        $fell(wr_n_o) |-> $past(!cs_n_o));

    // R6: bus word and kind do not move during the strobe
    assert_data_stable_R6: assert property (@(posedge clk) disable iff (rst)
        (!wr_n_o && $past(!wr_n_o)) |-> ($stable(bus_data_o) && $stable(a0_o)));

endmodule

// File: rtl/usbdc_init_seq.sv
module usbdc_init_seq
    import usbdc_init_pkg::*;
#(
    parameter int ROM_DEPTH       = 64,
    parameter int WR_CYCLES       = 4,
    parameter int RST_HOLD_CYCLES = 16,
    parameter int SETTLE_CYCLES   = 50000
) (
    input  logic        clk,
    input  logic        rst,
    output logic [15:0] usb_data_o,
    output logic        usb_a0_o,
    output logic        usb_a1_o,
    output logic        usb_cs_n_o,
    output logic        usb_wr_n_o,
    output logic        usb_rd_n_o,
    output logic        usb_rst_n_o,
    output logic        init_done_o
);

    localparam int AW      = $clog2(ROM_DEPTH);
    localparam int CNT_MAX = (RST_HOLD_CYCLES > SETTLE_CYCLES) ? RST_HOLD_CYCLES : SETTLE_CYCLES;
    localparam int CW      = $clog2(CNT_MAX + 1);

    seq_state_e    st;
    logic [AW-1:0] ptr;
    logic [CW-1:0] cnt;
    logic          kind_cmd;
    logic          chip_rst_n;
    logic [15:0]   rom_q;
    logic          is_mark;
    logic          start;
    logic          word_done;
    bus_word_t     issue_word;

    assign is_mark    = kind_cmd && (rom_q == END_MARK);
    assign start      = (st == SQ_DECODE) && !is_mark;
    assign issue_word = '{word: rom_q, is_cmd: kind_cmd};

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= SQ_RSTHOLD;
            cnt        <= CW'(RST_HOLD_CYCLES - 1);
            chip_rst_n <= 1'b0;
            ptr        <= '0;
            kind_cmd   <= 1'b1;
        end else begin
            case (st)
                SQ_RSTHOLD: begin
                    if (cnt == '0) begin
                        chip_rst_n <= 1'b1;
                        cnt        <= CW'(SETTLE_CYCLES - 1);
                        st         <= SQ_SETTLE;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                SQ_SETTLE: begin
                    if (cnt == '0) st <= SQ_FETCH;
                    else           cnt <= cnt - 1'b1;
                end
                SQ_FETCH:  st <= SQ_DECODE;
                SQ_DECODE: st <= is_mark ? SQ_DONE : SQ_ISSUE;
                SQ_ISSUE: begin
                    if (word_done) begin
                        if (ptr == AW'(ROM_DEPTH - 1)) begin
                            st <= SQ_DONE;
                        end else begin
                            ptr      <= ptr + 1'b1;
                            kind_cmd <= !kind_cmd;
                            st       <= SQ_FETCH;
                        end
                    end
                end
                SQ_DONE: st <= SQ_DONE;
                default: st <= SQ_DONE;
            endcase
        end
    end

    usbdc_init_rom #(.ROM_DEPTH(ROM_DEPTH)) u_rom (
        .clk   (clk),
        .addr  (ptr),
        .rdata (rom_q)
    );

    usbdc_bus_writer #(.WR_CYCLES(WR_CYCLES)) u_bus (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .word_in     (issue_word),
        .bus_data_o  (usb_data_o),
        .a0_o        (usb_a0_o),
        .cs_n_o      (usb_cs_n_o),
        .wr_n_o      (usb_wr_n_o),
        .word_done_o (word_done)
    );

    assign usb_a1_o    = 1'b1;
    assign usb_rd_n_o  = 1'b1;
    assign usb_rst_n_o = chip_rst_n;
    assign init_done_o = (st == SQ_DONE);

    // R2: never select the chip while it is held in reset
    assert_cs_after_release_R2: assert property (@(posedge clk) disable iff (rst)
        !usb_cs_n_o |-> usb_rst_n_o);

    // R10: completion is sticky until reset
    assert_done_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        init_done_o |=> init_done_o);

    // R8: a terminator in a command slot ends the run without a bus cycle
    assert_marker_stop_R8: assert property (@(posedge clk) disable iff (rst)
        (st == SQ_DECODE && is_mark) |=> (init_done_o && usb_cs_n_o));

    // R9: the final table address closes the run
    assert_last_addr_R9: assert property (@(posedge clk) disable iff (rst)
        (st == SQ_ISSUE && word_done && ptr == AW'(ROM_DEPTH - 1)) |=> init_done_o);

endmodule

// File: tb/usbdc_init_seq_bench.sv
module init_bus_watch #(
    parameter int WR_LEN   = 4,
    parameter int WAIT_LEN = 40
) (
    input logic        clk,
    input logic        rst,
    input logic [15:0] data,
    input logic        a0,
    input logic        a1,
    input logic        cs_n,
    input logic        wr_n,
    input logic        rd_n,
    input logic        chip_rst_n
);
    int n_wr, rst_low_cnt, rst_high_len, low_len;
    int early_err, width_err, setup_err, hold_err, stable_err, misc_err;
    logic        prev_wr, prev_cs, prev_a0;
    logic [15:0] prev_data;
    logic [15:0] cap_data [64];
    logic        cap_a0   [64];

    always @(negedge clk) begin
        if (rst) begin
            n_wr = 0; rst_low_cnt = 0; rst_high_len = 0; low_len = 0;
            early_err = 0; width_err = 0; setup_err = 0; hold_err = 0;
            stable_err = 0; misc_err = 0;
            prev_wr = 1'b1; prev_cs = 1'b1; prev_a0 = 1'b0; prev_data = '0;
        end else begin
            if (rd_n !== 1'b1 || a1 !== 1'b1) misc_err++;
            if (chip_rst_n === 1'b0) begin
                rst_low_cnt++;
                rst_high_len = 0;
                if (cs_n !== 1'b1) early_err++;
            end else begin
                rst_high_len++;
            end
            if (prev_wr && !wr_n) begin
                if (prev_cs !== 1'b0 || prev_data !== data || prev_a0 !== a0) setup_err++;
                if (rst_high_len < WAIT_LEN) early_err++;
                if (n_wr < 64) begin
                    cap_data[n_wr] = data;
                    cap_a0[n_wr]   = a0;
                end
                low_len = 1;
            end else if (!prev_wr && !wr_n) begin
                low_len++;
                if (data !== prev_data || a0 !== prev_a0 || cs_n !== 1'b0) stable_err++;
            end else if (!prev_wr && wr_n) begin
                if (low_len != WR_LEN) width_err++;
                if (cs_n !== 1'b0 || data !== prev_data || a0 !== prev_a0) hold_err++;
                n_wr++;
            end
            prev_wr = wr_n; prev_cs = cs_n; prev_a0 = a0; prev_data = data;
        end
    end
endmodule

module usbdc_init_seq_bench;
    localparam int CLK_PERIOD = 20;
    localparam int M_WR = 4, M_RST = 8, M_WAIT = 40;
    localparam int S_DEPTH = 16, S_WR = 2, S_RST = 4, S_WAIT = 10;
    localparam int FULL_WORDS = 38;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #(CLK_PERIOD / 2) clk = ~clk;

    int n_checks = 0;
    int n_fail   = 0;

    logic [15:0] m_data, s_data;
    logic m_a0, m_a1, m_cs, m_wr, m_rd, m_crst, m_done;
    logic s_a0, s_a1, s_cs, s_wr, s_rd, s_crst, s_done;

    usbdc_init_seq #(.ROM_DEPTH(64), .WR_CYCLES(M_WR), .RST_HOLD_CYCLES(M_RST),
                     .SETTLE_CYCLES(M_WAIT)) u_usbdc_init_seq (
        .clk(clk), .rst(rst), .usb_data_o(m_data), .usb_a0_o(m_a0), .usb_a1_o(m_a1),
        .usb_cs_n_o(m_cs), .usb_wr_n_o(m_wr), .usb_rd_n_o(m_rd),
        .usb_rst_n_o(m_crst), .init_done_o(m_done));

    usbdc_init_seq #(.ROM_DEPTH(S_DEPTH), .WR_CYCLES(S_WR), .RST_HOLD_CYCLES(S_RST),
                     .SETTLE_CYCLES(S_WAIT)) u_usbdc_init_seq_short (
        .clk(clk), .rst(rst), .usb_data_o(s_data), .usb_a0_o(s_a0), .usb_a1_o(s_a1),
        .usb_cs_n_o(s_cs), .usb_wr_n_o(s_wr), .usb_rd_n_o(s_rd),
        .usb_rst_n_o(s_crst), .init_done_o(s_done));

    init_bus_watch #(.WR_LEN(M_WR), .WAIT_LEN(M_WAIT)) u_watch_m (
        .clk(clk), .rst(rst), .data(m_data), .a0(m_a0), .a1(m_a1), .cs_n(m_cs),
        .wr_n(m_wr), .rd_n(m_rd), .chip_rst_n(m_crst));

    init_bus_watch #(.WR_LEN(S_WR), .WAIT_LEN(S_WAIT)) u_watch_s (
        .clk(clk), .rst(rst), .data(s_data), .a0(s_a0), .a1(s_a1), .cs_n(s_cs),
        .wr_n(s_wr), .rd_n(s_rd), .chip_rst_n(s_crst));

    // Expected table, written from R3
    function automatic logic [15:0] exp_word(input int i);
        logic [15:0] ep [16];
        foreach (ep[k]) ep[k] = 16'h0000;
        ep[0] = 16'h0083; ep[1] = 16'h008B; ep[2] = 16'h00CB;
        ep[3] = 16'h0080; ep[4] = 16'h0088;
        if (i >= 38) return 16'hFFFF;
        case (i)
            0: return 16'h00B8;
            1: return 16'h0008;
            2: return 16'h00BA;
            3: return 16'h0040;
            4: return 16'h00C2;
            5: return 16'h0107;
            default: return (i % 2 == 0) ? 16'h0020 + 16'((i - 6) / 2) : ep[(i - 6) / 2];
        endcase
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wait_done_m(input int limit);
        for (int c = 0; c < limit && m_done !== 1'b1; c++) @(posedge clk);
        @(posedge clk);
    endtask

    task automatic t_reset_state();
        @(negedge clk); rst <= 1'b1;
        repeat (4) @(negedge clk);
        chk("R1 chip reset low", int'(m_crst), 0);
        chk("R1 cs idle", int'(m_cs), 1);
        chk("R1 wr idle", int'(m_wr), 1);
        chk("R1 done low", int'(m_done), 0);
        chk("R7 rd idle", int'(m_rd), 1);
        chk("R7 mode select", int'(m_a1), 1);
    endtask

    task automatic t_full_run();
        @(negedge clk); rst <= 1'b0;
        wait_done_m(5000);
        chk("R8 done raised", int'(m_done), 1);
        chk("R8 word count", u_watch_m.n_wr, FULL_WORDS);
        // the cycle between reset release and the first edge is not sampled
        chk("R2 chip reset hold", u_watch_m.rst_low_cnt, M_RST - 1);
        chk("R2 early access", u_watch_m.early_err, 0);
        for (int i = 0; i < FULL_WORDS; i++) begin
            chk($sformatf("R3 word %0d", i), int'(u_watch_m.cap_data[i]), int'(exp_word(i)));
            chk($sformatf("R4 kind %0d", i), int'(u_watch_m.cap_a0[i]), (i % 2 == 0) ? 1 : 0);
        end
        chk("R5 strobe width", u_watch_m.width_err, 0);
        chk("R5 R6 setup", u_watch_m.setup_err, 0);
        chk("R5 R6 hold", u_watch_m.hold_err, 0);
        chk("R6 stable", u_watch_m.stable_err, 0);
        chk("R7 read/mode lines", u_watch_m.misc_err, 0);
        repeat (40) @(posedge clk);
        chk("R10 done sticky", int'(m_done), 1);
        chk("R10 no extra writes", u_watch_m.n_wr, FULL_WORDS);
    endtask

    task automatic t_short_run();
        chk("R9 short done", int'(s_done), 1);
        chk("R9 short count", u_watch_s.n_wr, S_DEPTH);
        for (int i = 0; i < S_DEPTH; i++)
            chk($sformatf("R9 short word %0d", i), int'(u_watch_s.cap_data[i]), int'(exp_word(i)));
        chk("R9 short strobe width", u_watch_s.width_err, 0);
        chk("R9 short early", u_watch_s.early_err, 0);
    endtask

    task automatic t_mid_reset();
        @(negedge clk); rst <= 1'b1;
        repeat (2) @(negedge clk);
        rst <= 1'b0;
        for (int c = 0; c < 5000 && u_watch_m.n_wr < 10; c++) @(posedge clk);
        @(negedge clk); rst <= 1'b1;
        repeat (2) @(negedge clk);
        chk("R10 abort cs", int'(m_cs), 1);
        chk("R10 abort wr", int'(m_wr), 1);
        chk("R10 abort done", int'(m_done), 0);
        chk("R10 abort chip reset", int'(m_crst), 0);
        rst <= 1'b0;
        wait_done_m(5000);
        chk("R10 restart count", u_watch_m.n_wr, FULL_WORDS);
        chk("R10 restart first", int'(u_watch_m.cap_data[0]), 16'h00B8);
        chk("R10 restart last", int'(u_watch_m.cap_data[37]), 16'h0000);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        t_reset_state();
        t_full_run();
        t_short_run();
        t_mid_reset();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule